// File: doc/BRIEF.md
# Backplane Bus Fault Watchdog

This block sits beside a board's processor and its backplane port and turns three kinds of bus trouble into one bus error exception for the processor. The first kind is a processor access that never receives an acknowledge. The second is the backplane error line being pulled low while this board holds the bus. The third is a fault reported by the read-modify-write lock logic. Each exception is a single-cycle pulse with a 2-bit code that says which cause was seen.

A board strapped as the backplane system controller also watches the two shared data strobes. If either strobe stays low for longer than the selected global limit, the block pulls the shared error line low so that the stuck cycle ends. It releases the line once both strobes are high again. On a board that is not the system controller, this strobe watchdog does nothing.

Both timers count microsecond ticks made by a free-running prescaler from the system clock. A timer therefore fires up to one tick earlier than its nominal count, measured from the start of the access or strobe.

Top module: `vme_fault_watch`

## Requirements
- R1: After reset `exc_pulse` is 0, `exc_cause` is 2'b00 and `berr_pull` is 0.
- R2: If `cpu_req` is held high with no `cpu_ack`, exactly one `exc_pulse` occurs with `exc_cause` = 2'b01. It comes between 13 ms and 15 ms after the access starts, and no further pulse follows while the same access stays pending.
- R3: A cycle with `cpu_ack` high ends the access and restarts the local window. A new access that stays pending times out between 13 ms and 15 ms after the acknowledge, not after the earlier start.
- R4: `berr_n` going low while `is_master` is high gives `exc_pulse` with `exc_cause` = 2'b10 on the next cycle. `berr_n` low while `is_master` is low gives no pulse and leaves `exc_cause` unchanged.
- R5: A rising edge on `rmw_fault` gives `exc_pulse` with `exc_cause` = 2'b11 on the next cycle.
- R6: When causes fall in the same cycle, the code reports the winner: lock fault (11) over qualified bus error (10) over local time-out (01).
- R7: `exc_pulse` lasts one cycle per event. A level that stays active produces no further pulse. `exc_cause` keeps the last reported code between pulses.
- R8: With `sys_ctrl` high, `berr_pull` goes high once `ds0_n` or `ds1_n` has stayed low for about 50 us when `to_sel` = 0, or about 57 us when `to_sel` = 1. The allowed error is one tick.
- R9: `berr_pull` stays high while either strobe is low and falls on the cycle after both strobes are high.
- R10: Raising both strobes clears the strobe timer, so two 40 us strobe periods separated by a release never trigger `berr_pull`.
- R11: With `sys_ctrl` low, `berr_pull` stays 0 however long the strobes are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access pending |
| cpu_ack | input | 1 | Processor access acknowledged |
| ds0_n | input | 1 | Backplane data strobe 0, active low |
| ds1_n | input | 1 | Backplane data strobe 1, active low |
| berr_n | input | 1 | Sampled backplane bus error line, active low |
| is_master | input | 1 | This board currently owns the backplane |
| sys_ctrl | input | 1 | Strap: board is the system controller |
| rmw_fault | input | 1 | Read-modify-write lock fault |
| to_sel | input | 1 | Global limit select: 0 = 50 us, 1 = 57 us |
| exc_pulse | output | 1 | Bus error exception, one-cycle pulse |
| exc_cause | output | 2 | Cause of the last exception: 01 local, 10 bus error, 11 lock |
| berr_pull | output | 1 | Open-drain enable: 1 pulls the error line low |

## Verification
A local counter that does not clear on an acknowledge shows up as an exception too early after a restarted access, within one 14 ms window. A strobe counter that does not clear shows up as `berr_pull` rising during the second of two short strobe periods. A wrong priority or a stuck edge register shows up at `exc_cause` or `exc_pulse` on the cycle after the stimulus. A drive enable that is latched too long shows up as `berr_pull` still high one cycle after both strobes are released.

// File: rtl/vme_fault_watch.sv
module vme_fault_watch #(
  parameter int CLK_PER_US   = 2,
  parameter int LOCAL_TO_US  = 14000,
  parameter int GLB_SHORT_US = 50,
  parameter int GLB_LONG_US  = 57
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_ack,
  input  logic       ds0_n,
  input  logic       ds1_n,
  input  logic       berr_n,
  input  logic       is_master,
  input  logic       sys_ctrl,
  input  logic       rmw_fault,
  input  logic       to_sel,
  output logic       exc_pulse,
  output logic [1:0] exc_cause,
  output logic       berr_pull
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int LW = $clog2(LOCAL_TO_US + 1);
  localparam int GW = $clog2(GLB_LONG_US + 1);

  logic [PW-1:0] pre;
  logic [LW-1:0] loc_cnt;
  logic [GW-1:0] g_cnt;
  logic          qb_q, rmw_q;

  wire tick      = (pre == PW'(CLK_PER_US - 1));
  wire loc_busy  = cpu_req && !cpu_ack;
  wire loc_fire  = loc_busy && tick && (loc_cnt == LW'(LOCAL_TO_US - 1));
  wire strobe_on = !ds0_n || !ds1_n;
  wire glb_run   = sys_ctrl && strobe_on;
  wire [GW-1:0] g_lim = to_sel ? GW'(GLB_LONG_US) : GW'(GLB_SHORT_US);
  wire qb        = is_master && !berr_n;
  wire berr_evt  = qb && !qb_q;
  wire rmw_evt   = rmw_fault && !rmw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !loc_busy)                        loc_cnt <= '0;
    else if (tick && loc_cnt != LW'(LOCAL_TO_US))   loc_cnt <= loc_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !glb_run) begin
      g_cnt     <= '0;
      berr_pull <= 1'b0;
    end else if (tick) begin
      if (g_cnt < g_lim)          g_cnt     <= g_cnt + 1'b1;
      if (g_cnt >= g_lim - 1'b1)  berr_pull <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qb_q      <= 1'b0;
      rmw_q     <= 1'b0;
      exc_pulse <= 1'b0;
      exc_cause <= 2'b00;
    end else begin
      qb_q      <= qb;
      rmw_q     <= rmw_fault;
      exc_pulse <= rmw_evt || berr_evt || loc_fire;
      if (rmw_evt)       exc_cause <= 2'b11;
      else if (berr_evt) exc_cause <= 2'b10;
      else if (loc_fire) exc_cause <= 2'b01;
    end
  end

  assert_no_drive_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_ctrl |=> !berr_pull);
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds0_n && ds1_n) |=> !berr_pull);
  assert_pulse_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> exc_cause != 2'b00);
  assert_berr_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_pulse && exc_cause == 2'b10) |-> ($past(is_master) && !$past(berr_n)));
  assert_rmw_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rmw_fault) |=> (exc_pulse && exc_cause == 2'b11));
  assert_drive_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_pull) |-> ($past(sys_ctrl) && (!$past(ds0_n) || !$past(ds1_n))));
endmodule

// File: tb/sim_vme_fault_watch.sv
module sim_vme_fault_watch;
  localparam int CLK_PERIOD = 10;
  localparam int CP = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_ack = 0, ds0_n = 1, ds1_n = 1, berr_n = 1;
  logic is_master = 0, sys_ctrl = 0, rmw_fault = 0, to_sel = 0;
  logic exc_pulse, berr_pull;
  logic [1:0] exc_cause;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vme_fault_watch #(.CLK_PER_US(CP)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
    .ds0_n(ds0_n), .ds1_n(ds1_n), .berr_n(berr_n), .is_master(is_master),
    .sys_ctrl(sys_ctrl), .rmw_fault(rmw_fault), .to_sel(to_sel),
    .exc_pulse(exc_pulse), .exc_cause(exc_cause), .berr_pull(berr_pull));

  // {is_master, berr_n, rmw_fault, exp_pulse, exp_cause[1:0]}, one cycle each
  localparam logic [5:0] VEC [10] = '{
    6'b110_0_00, 6'b000_0_00, 6'b100_1_10, 6'b100_0_10, 6'b111_1_11,
    6'b110_0_11, 6'b101_1_11, 6'b010_0_11, 6'b100_1_10, 6'b110_0_10};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic wait_pulse(int limit, output int n);
    n = 0;
    while (n < limit) begin
      step(); n++;
      if (exc_pulse) break;
    end
  endtask

  task automatic wait_pull(int limit, output int n);
    n = 0;
    while (n < limit) begin
      step(); n++;
      if (berr_pull) break;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n, extra;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pulse", exc_pulse, 0);
    chk("R1 cause", exc_cause, 0);
    chk("R1 pull", berr_pull, 0);
    @(negedge clk) rst_n = 1;

    // R4 R5 R6 R7 vector walk
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {is_master, berr_n, rmw_fault} = VEC[i][5:3];
      step();
      chk($sformatf("R4/R5/R6/R7 vec%0d pulse", i), exc_pulse, VEC[i][2]);
      chk($sformatf("R4/R5/R6/R7 vec%0d cause", i), exc_cause, VEC[i][1:0]);
    end
    @(negedge clk) begin is_master = 0; berr_n = 1; rmw_fault = 0; end

    // R8 short limit
    @(negedge clk) begin sys_ctrl = 1; to_sel = 0; ds0_n = 0; end
    wait_pull(200*CP, n);
    chk_rng("R8 50us", n, 49*CP, 50*CP + 1);
    @(negedge clk) begin ds0_n = 1; ds1_n = 0; end
    step();
    chk("R9 held by ds1", berr_pull, 1);
    @(negedge clk) ds1_n = 1;
    step();
    chk("R9 released", berr_pull, 0);

    // R8 long limit
    @(negedge clk) begin to_sel = 1; ds1_n = 0; end
    wait_pull(200*CP, n);
    chk_rng("R8 57us", n, 56*CP, 57*CP + 1);
    @(negedge clk) ds1_n = 1;
    step();
    chk("R9 released 57", berr_pull, 0);

    // R10 restart on release
    @(negedge clk) begin to_sel = 0; ds0_n = 0; end
    wait_pull(40*CP, n);
    @(negedge clk) ds0_n = 1;
    @(negedge clk) ds0_n = 0;
    wait_pull(40*CP, extra);
    chk("R10 no pull", berr_pull, 0);
    @(negedge clk) ds0_n = 1;

    // R11 not system controller
    @(negedge clk) begin sys_ctrl = 0; ds0_n = 0; ds1_n = 0; end
    wait_pull(200*CP, n);
    chk("R11 no pull", berr_pull, 0);
    @(negedge clk) begin ds0_n = 1; ds1_n = 1; end

    // R2 local timeout, once per access
    @(negedge clk) cpu_req = 1;
    wait_pulse(16000*CP, n);
    chk_rng("R2 window", n, 13000*CP, 15000*CP);
    chk("R2 cause", exc_cause, 1);
    extra = 0;
    repeat (3000) begin step(); if (exc_pulse) extra++; end
    chk("R2/R7 single pulse", extra, 0);
    @(negedge clk) cpu_req = 0;

    // R3 acknowledge restarts window
    @(negedge clk) cpu_req = 1;
    repeat (10000*CP) step();
    @(negedge clk) cpu_ack = 1;
    @(negedge clk) cpu_ack = 0;
    wait_pulse(16000*CP, n);
    chk_rng("R3 window after ack", n, 13000*CP - 1, 15000*CP);
    chk("R3 cause", exc_cause, 1);
    @(negedge clk) cpu_req = 0;

    finish_run();
  end
endmodule